// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences the sleep states of a small microcontroller. Software writes two mode bits. One selects a light sleep, in which the CPU clock stops while the peripheral clock and the oscillator keep running. The other selects a deep sleep, in which every clock and the oscillator stop. The block gives the clock-gating logic enable signals for the CPU clock, the peripheral clock and the oscillator. It also drives a reset strobe for the special function registers and a write-inhibit line for the internal RAM.

Light sleep ends when any interrupt request whose enable bit is set is asserted. It also ends on the hardware reset pin. When the reset pin ends light sleep, the CPU clock runs for a short window before the reset strobe begins, and RAM writes are blocked during that window. Deep sleep ends only through the hardware reset pin. The oscillator then restarts, and the CPU clock stays gated until a programmable settling count has run out. A reset strobe clears only the special function registers. The block never asks for the RAM to be cleared.

Top module: `pmc_power_ctrl`

## Requirements
- R1: In run state, a write (`mode_wr`=1) with `wr_idle`=1 and `wr_pdown`=0 enters light sleep at the next clock edge. In light sleep `cpu_clk_en`=0, `per_clk_en`=1, `osc_en`=1 and `mode_idle`=1.
- R2: In run state, a write with `wr_pdown`=1 enters deep sleep at the next edge, whatever the value of `wr_idle`. In deep sleep `cpu_clk_en`, `per_clk_en` and `osc_en` are all 0 and `mode_pdown`=1.
- R3: In light sleep, with `hw_rst`=0, any bit i with `irq_req[i]`=1 and `irq_en[i]`=1 returns the block to run state at the next edge. In run state all three enables are 1 and both mode bits are 0. A request whose enable bit is 0 has no effect.
- R4: Interrupt requests have no effect in deep sleep. The block stays in deep sleep until `hw_rst`=1.
- R5: `hw_rst`=1 in deep sleep starts a settling phase at the next edge. The settling phase lasts `stab_cycles`+1 clocks, with `osc_en`=1, `cpu_clk_en`=0, `per_clk_en`=0 and `sfr_rst`=1. A reset phase follows, with all enables 1 and `sfr_rst`=1. The reset phase lasts while `hw_rst`=1, and the block returns to run state one clock after `hw_rst` falls.
- R6: `hw_rst`=1 in light sleep starts a window of 2·MC_CLKS clocks. During the window `cpu_clk_en`=1, `ram_wr_inhibit`=1, `sfr_rst`=0 and both mode bits are 0. The reset phase of R5 follows.
- R7: `hw_rst`=1 in run state enters the reset phase at the next edge, and this takes precedence over a mode write in the same cycle. `ram_wr_inhibit` is 1 only inside the R6 window and is never 1 while `sfr_rst`=1.
- R8: Mode writes made in light sleep, deep sleep, the window, settling or the reset phase are ignored.
- R9: While `rst_n`=0 at a clock edge, the block enters run state. In run state `cpu_clk_en`=`per_clk_en`=`osc_en`=1 and `sfr_rst`=`ram_wr_inhibit`=`mode_idle`=`mode_pdown`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| mode_wr | input | 1 | Mode register write strobe |
| wr_idle | input | 1 | Light-sleep bit of the write |
| wr_pdown | input | 1 | Deep-sleep bit of the write |
| irq_req | input | N_IRQ | Interrupt request lines |
| irq_en | input | N_IRQ | Interrupt enable mask |
| hw_rst | input | 1 | Hardware reset pin, active high |
| stab_cycles | input | CNT_W | Oscillator settling count after deep sleep |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| sfr_rst | output | 1 | Special function register reset strobe |
| ram_wr_inhibit | output | 1 | Internal RAM write block |
| mode_idle | output | 1 | Light-sleep mode bit |
| mode_pdown | output | 1 | Deep-sleep mode bit |

## Verification
The bench builds the block with MC_CLKS=2, which makes the light-sleep reset window four clocks, and with CNT_W=8. Each window and each settling phase can then be walked through to its last cycle. Settling counts of 3 and 0 exercise both the normal phase length and the shortest one-clock phase. Three interrupt lines let the bench use the mask against a pending request, and raise several requests at once while in deep sleep.

// File: rtl/pmc_pkg.sv
// Package pmc_pkg
// Shared types of the power-mode controller: the sequencer state and the
// bundle of control outputs decoded from it. Assumes no other users.
package pmc_pkg;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_IDLE   = 3'd1,
        ST_PDOWN  = 3'd2,
        ST_RSTWIN = 3'd3,
        ST_RESET  = 3'd4,
        ST_STAB   = 3'd5
    } pmc_state_t;

    typedef struct packed {
        logic cpu;
        logic per;
        logic osc;
        logic sfr;
        logic inh;
        logic midle;
        logic mpd;
    } pmc_ctl_t;

endpackage

// File: rtl/pmc_wake_detect.sv
// Module pmc_wake_detect
// Masks the interrupt requests with their enables and ORs the result into a
// single wake request. Purely combinational; requests are assumed synchronous.
module pmc_wake_detect #(
    parameter int N_IRQ = 3
) (
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    output logic             wake
);

    logic [N_IRQ-1:0] masked;

    // one AND gate per request line
    for (genvar g = 0; g < N_IRQ; g++) begin : g_mask
        assign masked[g] = irq_req[g] & irq_en[g];
    end

    assign wake = |masked;

endmodule

// File: rtl/pmc_down_counter.sv
// Module pmc_down_counter
// Loadable down counter that times the light-sleep reset window and the
// oscillator settling phase. It holds at zero; a load wins over a decrement.
module pmc_down_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);

    logic [CNT_W-1:0] cnt;

    // count register: load, step down, or hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // counter steps by exactly one while decrementing
    a_r5_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && dec && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/pmc_out_decode.sv
// Module pmc_out_decode
// Maps the sequencer state onto the clock enables, the reset strobe, the RAM
// write block and the two mode bits. Combinational; state is registered.
module pmc_out_decode
    import pmc_pkg::*;
(
    input  pmc_state_t state,
    output pmc_ctl_t   ctl
);

    // one row of control values per state
    always_comb begin
        ctl = '{cpu: 1'b1, per: 1'b1, osc: 1'b1, sfr: 1'b0,
                inh: 1'b0, midle: 1'b0, mpd: 1'b0};
        case (state)
            ST_IDLE:   begin ctl.cpu = 1'b0; ctl.midle = 1'b1; end
            ST_PDOWN:  begin ctl.cpu = 1'b0; ctl.per = 1'b0;
                             ctl.osc = 1'b0; ctl.mpd = 1'b1; end
            ST_RSTWIN: ctl.inh = 1'b1;
            ST_RESET:  ctl.sfr = 1'b1;
            ST_STAB:   begin ctl.cpu = 1'b0; ctl.per = 1'b0;
                             ctl.sfr = 1'b1; end
            default:   ;
        endcase
    end

endmodule

// File: rtl/pmc_power_ctrl.sv
// Module pmc_power_ctrl (top)
// Sequences entry into and exit from light sleep and deep sleep. Assumes the
// mode write strobe, interrupt lines and hardware reset pin are synchronous
// to clk. The reset window is WIN_MC machine cycles of MC_CLKS clocks each.
module pmc_power_ctrl
    import pmc_pkg::*;
#(
    parameter int N_IRQ   = 3,
    parameter int CNT_W   = 16,
    parameter int MC_CLKS = 12,
    parameter int WIN_MC  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic             wr_idle,
    input  logic             wr_pdown,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             hw_rst,
    input  logic [CNT_W-1:0] stab_cycles,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             osc_en,
    output logic             sfr_rst,
    output logic             ram_wr_inhibit,
    output logic             mode_idle,
    output logic             mode_pdown
);

    localparam int               WIN_CLKS = MC_CLKS * WIN_MC;
    localparam logic [CNT_W-1:0] WIN_LOAD = CNT_W'(WIN_CLKS - 1);

    pmc_state_t       state, state_nx;
    pmc_ctl_t         ctl;
    logic             wake, cnt_zero, cnt_load, cnt_dec;
    logic [CNT_W-1:0] cnt_val;

    pmc_wake_detect #(.N_IRQ(N_IRQ)) u_wake (
        .irq_req (irq_req),
        .irq_en  (irq_en),
        .wake    (wake)
    );

    pmc_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .zero     (cnt_zero)
    );

    pmc_out_decode u_dec (
        .state (state),
        .ctl   (ctl)
    );

    // next state and counter load selection
    always_comb begin
        state_nx = state;
        cnt_load = 1'b0;
        cnt_val  = WIN_LOAD;
        cnt_dec  = (state == ST_RSTWIN) || (state == ST_STAB);
        case (state)
            ST_RUN: begin
                if (hw_rst)
                    state_nx = ST_RESET;
                else if (mode_wr && wr_pdown)
                    state_nx = ST_PDOWN;
                else if (mode_wr && wr_idle)
                    state_nx = ST_IDLE;
            end
            ST_IDLE: begin
                if (hw_rst) begin
                    state_nx = ST_RSTWIN;
                    cnt_load = 1'b1;
                end else if (wake)
                    state_nx = ST_RUN;
            end
            ST_PDOWN: begin
                if (hw_rst) begin
                    state_nx = ST_STAB;
                    cnt_load = 1'b1;
                    cnt_val  = stab_cycles;
                end
            end
            ST_RSTWIN, ST_STAB: begin
                if (cnt_zero)
                    state_nx = ST_RESET;
            end
            ST_RESET: begin
                if (!hw_rst)
                    state_nx = ST_RUN;
            end
            default: state_nx = ST_RUN;
        endcase
    end

    // sequencer state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_RUN;
        else
            state <= state_nx;
    end

    assign cpu_clk_en     = ctl.cpu;
    assign per_clk_en     = ctl.per;
    assign osc_en         = ctl.osc;
    assign sfr_rst        = ctl.sfr;
    assign ram_wr_inhibit = ctl.inh;
    assign mode_idle      = ctl.midle;
    assign mode_pdown     = ctl.mpd;

    // R1: light-sleep write stops the CPU clock next cycle
    a_r1_idle_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !hw_rst && mode_wr && wr_idle && !wr_pdown)
        |=> (mode_idle && !cpu_clk_en && per_clk_en));

    // R2: deep-sleep bit wins over the light-sleep bit
    a_r2_pd_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !hw_rst && mode_wr && wr_pdown)
        |=> (mode_pdown && !osc_en && !mode_idle));

    // R3: enabled interrupt ends light sleep
    a_r3_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_idle && !hw_rst && wake) |=> (cpu_clk_en && !mode_idle));

    // R4: only the reset pin leaves deep sleep
    a_r4_pd_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_pdown && !hw_rst) |=> mode_pdown);

    // R5: oscillator restarts with the CPU clock still gated
    a_r5_osc_restart: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_en) |-> (!cpu_clk_en && sfr_rst));

    // R6: RAM write block hands over directly to the reset strobe
    a_r6_window_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ram_wr_inhibit) |-> sfr_rst);

    // R7: RAM writes are never blocked during the reset strobe
    a_r7_no_inhibit_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_rst |-> !ram_wr_inhibit);

endmodule

// File: tb/tb_pmc_power_ctrl.sv
// Bench for pmc_power_ctrl: a behavioural reference model steps on every
// rising edge and all outputs are compared on every falling edge.
module tb_pmc_power_ctrl;

    localparam int N_IRQ   = 3;
    localparam int CNT_W   = 8;
    localparam int MC_CLKS = 2;
    localparam int WIN     = MC_CLKS * 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_wr = 1'b0, wr_idle = 1'b0, wr_pdown = 1'b0;
    logic [N_IRQ-1:0] irq_req = '0, irq_en = '0;
    logic             hw_rst = 1'b0;
    logic [CNT_W-1:0] stab_cycles = 8'd3;
    logic cpu_clk_en, per_clk_en, osc_en, sfr_rst, ram_wr_inhibit, mode_idle, mode_pdown;

    int    n_run = 0, n_fail = 0;
    bit    done = 1'b0;
    string cur_req = "R9";

    always #10 clk = ~clk;

    pmc_power_ctrl #(.N_IRQ(N_IRQ), .CNT_W(CNT_W), .MC_CLKS(MC_CLKS), .WIN_MC(2)) dut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .wr_idle(wr_idle),
        .wr_pdown(wr_pdown), .irq_req(irq_req), .irq_en(irq_en),
        .hw_rst(hw_rst), .stab_cycles(stab_cycles), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .osc_en(osc_en), .sfr_rst(sfr_rst),
        .ram_wr_inhibit(ram_wr_inhibit), .mode_idle(mode_idle), .mode_pdown(mode_pdown)
    );

    // model modes: 0 run, 1 light sleep, 2 deep sleep, 3 window, 4 reset, 5 settling
    int m_mode = 0;
    int m_cnt  = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0;
            m_cnt  = 0;
        end else begin
            case (m_mode)
                0: if (hw_rst) m_mode = 4;
                   else if (mode_wr && wr_pdown) m_mode = 2;
                   else if (mode_wr && wr_idle) m_mode = 1;
                1: if (hw_rst) begin m_mode = 3; m_cnt = WIN - 1; end
                   else if ((irq_req & irq_en) != 0) m_mode = 0;
                2: if (hw_rst) begin m_mode = 5; m_cnt = int'(stab_cycles); end
                3, 5: if (m_cnt == 0) m_mode = 4; else m_cnt = m_cnt - 1;
                4: if (!hw_rst) m_mode = 0;
                default: m_mode = 0;
            endcase
        end
    end

    // expected {cpu, per, osc, sfr, inhibit, idle bit, deep bit}
    function automatic logic [6:0] expect_of(int mode);
        case (mode)
            1: return 7'b0110010;
            2: return 7'b0000001;
            3: return 7'b1110100;
            4: return 7'b1111000;
            5: return 7'b0011000;
            default: return 7'b1110000;
        endcase
    endfunction

    task automatic tick();
        logic [6:0] got, exp;
        @(posedge clk);
        @(negedge clk);
        got = {cpu_clk_en, per_clk_en, osc_en, sfr_rst, ram_wr_inhibit, mode_idle, mode_pdown};
        exp = expect_of(m_mode);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs %b expected %b", cur_req, got, exp);
        end
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic write_mode(logic idle_b, logic pd_b);
        mode_wr = 1'b1; wr_idle = idle_b; wr_pdown = pd_b;
        tick();
        mode_wr = 1'b0; wr_idle = 1'b0; wr_pdown = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R9: block reset state
        cur_req = "R9";
        @(negedge clk);
        ticks(2);
        rst_n = 1'b1;
        ticks(2);

        // R1: enter light sleep
        cur_req = "R1";
        write_mode(1'b1, 1'b0);
        ticks(3);

        // R3: masked request ignored, then enabled request wakes
        cur_req = "R3";
        irq_req = 3'b001; irq_en = 3'b110;
        ticks(3);
        irq_en = 3'b011;
        tick();
        irq_req = '0; irq_en = '0;
        ticks(2);

        // R2: both bits written, deep sleep wins
        cur_req = "R2";
        write_mode(1'b1, 1'b1);
        tick();

        // R4: requests ignored in deep sleep
        cur_req = "R4";
        irq_req = 3'b111; irq_en = 3'b111;
        ticks(5);
        irq_req = '0; irq_en = '0;

        // R8: write in deep sleep ignored
        cur_req = "R8";
        write_mode(1'b1, 1'b0);
        ticks(2);

        // R5: reset leaves deep sleep through settling (count 3)
        cur_req = "R5";
        stab_cycles = 8'd3;
        hw_rst = 1'b1;
        ticks(8);
        hw_rst = 1'b0;
        ticks(2);

        // R6: reset during light sleep opens the RAM write block window
        cur_req = "R6";
        write_mode(1'b1, 1'b0);
        tick();
        hw_rst = 1'b1;
        ticks(WIN + 3);
        hw_rst = 1'b0;
        ticks(2);

        // R6: short reset pulse in light sleep, window still runs to its end
        write_mode(1'b1, 1'b0);
        hw_rst = 1'b1;
        tick();
        hw_rst = 1'b0;
        ticks(WIN + 2);

        // R7: reset in run state beats a simultaneous mode write
        cur_req = "R7";
        hw_rst = 1'b1;
        write_mode(1'b0, 1'b1);
        ticks(3);
        hw_rst = 1'b0;
        ticks(2);

        // R5: shortest settling phase (count 0)
        cur_req = "R5";
        write_mode(1'b0, 1'b1);
        stab_cycles = 8'd0;
        hw_rst = 1'b1;
        ticks(3);
        hw_rst = 1'b0;
        ticks(2);

        // R8: deep-sleep write during light sleep ignored, then wake
        cur_req = "R8";
        write_mode(1'b1, 1'b0);
        write_mode(1'b0, 1'b1);
        ticks(2);
        irq_req = 3'b100; irq_en = 3'b100;
        tick();
        irq_req = '0; irq_en = '0;
        ticks(2);

        // R9: block reset from deep sleep returns to run
        cur_req = "R9";
        write_mode(1'b0, 1'b1);
        rst_n = 1'b0;
        ticks(2);
        rst_n = 1'b1;
        ticks(2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule